// File: doc/BRIEF.md
# UART FIFO pair with fill index

This block holds the character queues of a serial port. A transmit queue of bytes is filled by the CPU and drained by the transmit shifter. A receive queue is filled by the receive shifter and drained by the CPU. Each receive entry is ten bits wide: eight data bits plus a parity-error flag and a framing-error flag, kept with the character they belong to.

Software sees the block through two registers. A read-only index register reports both fill counts. A FIFO control register holds the queue-mode enable and two self-clearing flush requests, which software polls until they drop. The block also drives the level flags that an interrupt unit would consume, a one-cycle overrun pulse, and an optional bus-error strobe for reads from an empty receive queue.

Top module: `uart_fifo_pair`

## Requirements
- R1: Bytes pushed by the CPU leave on `txData` in push order. `txPop` removes the head entry. The default depth is 16.
- R2: A receive entry holds the data in bits 7:0, the parity-error flag in bit 8 and the framing-error flag in bit 9. Entries are read at `cpuRxData` in arrival order, and `cpuRxPop` removes the head.
- R3: In `idxRdata`, bits 4:0 give the transmit count and bits 12:8 give the receive count, each from 0 to 16. All other bits read zero. Both counts are zero after reset.
- R4: Bit 0 of the control register enables queue mode and resets to 0. While it is 0, each queue holds at most one entry.
- R5: Writing a 1 to control bit 2 (receive) or bit 3 (transmit) makes that bit read 1 after the write edge. On the following edge the queue empties and the bit reads 0. A push in the same cycle as that flush edge is dropped.
- R6: A push to a full queue is dropped and leaves the contents unchanged. A dropped receive push raises `rxOverrun` for exactly the next cycle.
- R7: A CPU pop from an empty receive queue leaves the count unchanged. `cpuRxData` reads zero whenever the receive queue is empty.
- R8: When `errOnEmptyEn` is 1, a CPU pop of an empty receive queue drives `cpuBusErr` high in that same cycle. When `errOnEmptyEn` is 0, `cpuBusErr` stays low.
- R9: `rxAlmostFull` is high at a receive count of 12 or more. `rxFull` is high at 16. `txAlmostEmpty` is high at a transmit count of 4 or fewer. `txEmpty` is high at 0.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuTxPush | input | 1 | CPU writes a byte to the transmit queue |
| cpuTxData | input | 8 | Byte to enqueue |
| txPop | input | 1 | Transmit shifter takes the head byte |
| txData | output | 8 | Transmit head byte |
| rxPush | input | 1 | Receive shifter delivers a character |
| rxData | input | 8 | Received byte |
| rxParErr | input | 1 | Parity error for this character |
| rxFrmErr | input | 1 | Framing error for this character |
| cpuRxPop | input | 1 | CPU takes the receive head |
| cpuRxData | output | 10 | Receive head entry, zero when empty |
| errOnEmptyEn | input | 1 | Line-control option: flag a bus error on an empty read |
| cpuBusErr | output | 1 | Bus error for the current empty read |
| ctlWrite | input | 1 | Write strobe for the control register |
| ctlWdata | input | 4 | Control write data |
| ctlRdata | output | 4 | Control readback |
| idxRdata | output | 16 | Fill index register |
| rxOverrun | output | 1 | Dropped receive push, one-cycle pulse |
| rxAlmostFull | output | 1 | Receive count at or above 12 |
| rxFull | output | 1 | Receive queue full |
| txAlmostEmpty | output | 1 | Transmit count at or below 4 |
| txEmpty | output | 1 | Transmit queue empty |

## Verification
The bench builds the block with its default parameters: 16-deep queues, an almost-full level of 12 and an almost-empty level of 4. With these values a sixteen-push run reaches the full boundary and the dropped seventeenth push. The same run steps the receive count across the almost-full level one character at a time, and the drain passes through the almost-empty level of the transmit queue. Because the defaults keep both counts within five bits, the two count fields sit exactly at bits 4:0 and 12:8 of the index word.

// File: rtl/uff_pkg.sv
package uff_pkg;
  typedef struct packed {
    logic txWe;
    logic txRe;
    logic txClr;
    logic rxWe;
    logic rxRe;
    logic rxClr;
  } uffStrobes_t;
endpackage

// File: rtl/uff_store.sv
module uff_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         we,
  input  logic         re,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] head
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (we) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (re) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wrPtr] <= wdata;
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/uff_datapath.sv
module uff_datapath
  import uff_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  uffStrobes_t       stb,
  input  logic [DATA_W-1:0] txIn,
  input  logic [DATA_W+1:0] rxIn,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W+1:0] rxHead
);
  uff_store #(.DEPTH(TX_DEPTH), .W(DATA_W)) i_txStore (
    .clk(clk), .rstN(rstN), .we(stb.txWe), .re(stb.txRe), .clr(stb.txClr),
    .wdata(txIn), .head(txHead)
  );

  uff_store #(.DEPTH(RX_DEPTH), .W(DATA_W + 2)) i_rxStore (
    .clk(clk), .rstN(rstN), .we(stb.rxWe), .re(stb.rxRe), .clr(stb.rxClr),
    .wdata(rxIn), .head(rxHead)
  );
endmodule

// File: rtl/uff_ctrl.sv
module uff_ctrl
  import uff_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int AF_LEVEL = 12,
  parameter int AE_LEVEL = 4,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuTxPush,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic          cpuRxPop,
  input  logic          ctlWrite,
  input  logic [3:0]    ctlWdata,
  output uffStrobes_t   stb,
  output logic [CW-1:0] txCnt,
  output logic [CW-1:0] rxCnt,
  output logic [3:0]    ctlRdata,
  output logic          rxOverrun,
  output logic          rxAlmostFull,
  output logic          rxFull,
  output logic          txAlmostEmpty,
  output logic          txEmpty
);
  localparam logic [CW-1:0] TX_MAX = CW'(TX_DEPTH);
  localparam logic [CW-1:0] RX_MAX = CW'(RX_DEPTH);
  localparam logic [CW-1:0] AF_CNT = CW'(AF_LEVEL);
  localparam logic [CW-1:0] AE_CNT = CW'(AE_LEVEL);

  logic fifoEn, rxFlushPend, txFlushPend;
  logic [CW-1:0] txLimit, rxLimit;
  logic unusedCtlBit;

  assign unusedCtlBit = ctlWdata[1];
  assign txLimit = fifoEn ? TX_MAX : CW'(1);
  assign rxLimit = fifoEn ? RX_MAX : CW'(1);

  always_comb begin
    stb.txClr = txFlushPend;
    stb.rxClr = rxFlushPend;
    stb.txWe  = cpuTxPush && (txCnt < txLimit) && !txFlushPend;
    stb.txRe  = txPop && (txCnt != '0) && !txFlushPend;
    stb.rxWe  = rxPush && (rxCnt < rxLimit) && !rxFlushPend;
    stb.rxRe  = cpuRxPop && (rxCnt != '0) && !rxFlushPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEn      <= 1'b0;
      rxFlushPend <= 1'b0;
      txFlushPend <= 1'b0;
    end else begin
      if (ctlWrite) fifoEn <= ctlWdata[0];
      rxFlushPend <= ctlWrite && ctlWdata[2];
      txFlushPend <= ctlWrite && ctlWdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt     <= '0;
      rxCnt     <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (stb.txClr)                 txCnt <= '0;
      else if (stb.txWe && !stb.txRe) txCnt <= txCnt + 1'b1;
      else if (!stb.txWe && stb.txRe) txCnt <= txCnt - 1'b1;

      if (stb.rxClr)                 rxCnt <= '0;
      else if (stb.rxWe && !stb.rxRe) rxCnt <= rxCnt + 1'b1;
      else if (!stb.rxWe && stb.rxRe) rxCnt <= rxCnt - 1'b1;

      rxOverrun <= rxPush && !rxFlushPend && (rxCnt >= rxLimit);
    end
  end

  assign ctlRdata      = {txFlushPend, rxFlushPend, 1'b0, fifoEn};
  assign rxAlmostFull  = rxCnt >= AF_CNT;
  assign rxFull        = rxCnt == RX_MAX;
  assign txAlmostEmpty = txCnt <= AE_CNT;
  assign txEmpty       = txCnt == '0;
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uff_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16,
  parameter int DATA_W   = 8,
  parameter int AF_LEVEL = 12,
  parameter int AE_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTxPush,
  input  logic [DATA_W-1:0] cpuTxData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              cpuRxPop,
  output logic [DATA_W+1:0] cpuRxData,
  input  logic              errOnEmptyEn,
  output logic              cpuBusErr,
  input  logic              ctlWrite,
  input  logic [3:0]        ctlWdata,
  output logic [3:0]        ctlRdata,
  output logic [15:0]       idxRdata,
  output logic              rxOverrun,
  output logic              rxAlmostFull,
  output logic              rxFull,
  output logic              txAlmostEmpty,
  output logic              txEmpty
);
  localparam int MAXD = (TX_DEPTH > RX_DEPTH) ? TX_DEPTH : RX_DEPTH;
  localparam int CW   = $clog2(MAXD + 1);

  uffStrobes_t       stb;
  logic [CW-1:0]     txCnt, rxCnt;
  logic [DATA_W+1:0] rxHead;

  uff_ctrl #(
    .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
    .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL), .CW(CW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cpuTxPush(cpuTxPush), .txPop(txPop),
    .rxPush(rxPush), .cpuRxPop(cpuRxPop), .ctlWrite(ctlWrite),
    .ctlWdata(ctlWdata), .stb(stb), .txCnt(txCnt), .rxCnt(rxCnt),
    .ctlRdata(ctlRdata), .rxOverrun(rxOverrun), .rxAlmostFull(rxAlmostFull),
    .rxFull(rxFull), .txAlmostEmpty(txAlmostEmpty), .txEmpty(txEmpty)
  );

  uff_datapath #(
    .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txIn(cpuTxData),
    .rxIn({rxFrmErr, rxParErr, rxData}), .txHead(txData), .rxHead(rxHead)
  );

  assign cpuRxData = (rxCnt == '0) ? '0 : rxHead;
  assign cpuBusErr = errOnEmptyEn && cpuRxPop && (rxCnt == '0);
  assign idxRdata  = {8'(rxCnt), 8'(txCnt)};
endmodule

// File: rtl/uff_checker.sv
module uff_checker #(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        cpuTxPush,
  input logic        txPop,
  input logic        rxPush,
  input logic        cpuRxPop,
  input logic        ctlWrite,
  input logic [3:0]  ctlRdata,
  input logic [15:0] idxRdata,
  input logic        rxOverrun,
  input logic        cpuBusErr,
  input logic        txEmpty
);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxRdata[7:0] <= 8'(TX_DEPTH)) && (idxRdata[15:8] <= 8'(RX_DEPTH)));
  // R5
  rx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdata[2] |=> idxRdata[15:8] == 8'd0);
  // R5
  tx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdata[3] |=> idxRdata[7:0] == 8'd0);
  // R5
  flush_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdata[3] && !ctlWrite) |=> !ctlRdata[3]);
  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> $past(rxPush));
  // R8
  bus_err_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuBusErr |-> idxRdata[15:8] == 8'd0);
  // R7
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRxPop && idxRdata[15:8] == 8'd0 && !rxPush) |=> idxRdata[15:8] == 8'd0);
  // R9
  tx_empty_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> idxRdata[7:0] == 8'd0);
  // R10
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTxPush && txPop && ctlRdata[0] && !ctlRdata[3] && idxRdata[7:0] != 8'd0
     && idxRdata[7:0] < 8'(TX_DEPTH)) |=> idxRdata[7:0] == $past(idxRdata[7:0]));
endmodule

bind uart_fifo_pair uff_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) i_chk (.*);

// File: tb/test_uart_fifo_pair.sv
module test_uart_fifo_pair;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuTxPush = 0, txPop = 0, rxPush = 0, rxParErr = 0, rxFrmErr = 0;
  logic cpuRxPop = 0, errOnEmptyEn = 0, ctlWrite = 0;
  logic [7:0] cpuTxData = 0, rxData = 0, txData;
  logic [9:0] cpuRxData;
  logic [3:0] ctlWdata = 0, ctlRdata;
  logic [15:0] idxRdata;
  logic cpuBusErr, rxOverrun, rxAlmostFull, rxFull, txAlmostEmpty, txEmpty;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  uart_fifo_pair i_uart_fifo_pair (.*);

  typedef struct packed {
    logic       push;
    logic       pop;
    logic [7:0] data;
    logic [4:0] expCnt;
    logic [7:0] expHead;
  } vec_t;

  // R1 / R10: transmit queue vectors
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 8'hA5, 5'd1, 8'hA5},
    '{1'b1, 1'b0, 8'h3C, 5'd2, 8'hA5},
    '{1'b1, 1'b1, 8'h77, 5'd2, 8'h3C},
    '{1'b0, 1'b1, 8'h00, 5'd1, 8'h77},
    '{1'b0, 1'b1, 8'h00, 5'd0, 8'h00},
    '{1'b0, 1'b1, 8'h00, 5'd0, 8'h00},
    '{1'b1, 1'b0, 8'h11, 5'd1, 8'h11},
    '{1'b0, 1'b1, 8'h00, 5'd0, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    cpuTxPush = 0; txPop = 0; rxPush = 0; cpuRxPop = 0; ctlWrite = 0;
    rxParErr = 0; rxFrmErr = 0;
  endtask

  task automatic rxIn(input logic [7:0] d, input logic p, input logic f);
    @(negedge clk);
    rxPush = 1; rxData = d; rxParErr = p; rxFrmErr = f;
    tick();
  endtask

  task automatic ctl(input logic [3:0] v);
    @(negedge clk);
    ctlWrite = 1; ctlWdata = v;
    tick();
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R3 R4 R9: reset state
    chk(idxRdata == 16'h0, "R3 reset index", idxRdata, 0);
    chk(ctlRdata == 4'h0, "R4 reset control", ctlRdata, 0);
    chk(txEmpty && txAlmostEmpty && !rxAlmostFull && !rxFull, "R9 reset flags",
        {txEmpty, txAlmostEmpty, rxAlmostFull, rxFull}, 4'b1100);
    chk(cpuRxData == 10'h0, "R7 empty read zero", cpuRxData, 0);

    // R4 R6: queue mode off holds one entry; second push overruns
    rxIn(8'h5A, 1'b0, 1'b0);
    chk(!rxOverrun, "R6 no overrun on accepted push", rxOverrun, 0);
    rxIn(8'h66, 1'b1, 1'b1);
    chk(idxRdata[12:8] == 5'd1, "R4 single entry when disabled", idxRdata[12:8], 1);
    chk(rxOverrun, "R6 overrun pulse", rxOverrun, 1);
    chk(cpuRxData == 10'h05A, "R6 contents kept", cpuRxData, 10'h05A);
    @(negedge clk); tick();
    chk(!rxOverrun, "R6 overrun lasts one cycle", rxOverrun, 0);
    @(negedge clk); cpuRxPop = 1; tick();
    chk(idxRdata[12:8] == 5'd0, "R4 pop back to empty", idxRdata[12:8], 0);

    ctl(4'b0001);
    chk(ctlRdata[0], "R4 enable readback", ctlRdata, 1);

    // R1 R10: vector walk on the transmit queue
    foreach (VEC[i]) begin
      @(negedge clk);
      cpuTxPush = VEC[i].push; txPop = VEC[i].pop; cpuTxData = VEC[i].data;
      tick();
      chk(idxRdata[4:0] == VEC[i].expCnt, "R1 R10 tx count", idxRdata[4:0], VEC[i].expCnt);
      if (VEC[i].expCnt != 0)
        chk(txData == VEC[i].expHead, "R1 tx head", txData, VEC[i].expHead);
    end

    // R2 R6 R9: fill receive queue
    for (int i = 0; i < 16; i++) begin
      logic [3:0] n;
      n = 4'(i);
      rxIn(8'h40 + 8'(i), n[0], n[1]);
      chk(rxAlmostFull == (i + 1 >= 12), "R9 almost full level", rxAlmostFull, (i + 1 >= 12));
    end
    chk(rxFull && idxRdata[12:8] == 5'd16, "R9 R3 rx full at 16", idxRdata[12:8], 16);
    chk(idxRdata[15:13] == 3'b0 && idxRdata[7:5] == 3'b0, "R3 spare bits zero", idxRdata, 16'h1000);
    rxIn(8'hEE, 1'b0, 1'b0);
    chk(rxOverrun && idxRdata[12:8] == 5'd16, "R6 drop on full", idxRdata[12:8], 16);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] n;
      logic [9:0] e;
      n = 4'(i);
      e = {n[1], n[0], 8'h40 + 8'(i)};
      chk(cpuRxData == e, "R2 rx entry layout and order", cpuRxData, e);
      @(negedge clk); cpuRxPop = 1; tick();
    end
    chk(idxRdata[12:8] == 5'd0, "R2 drained", idxRdata[12:8], 0);

    // R7 R8: empty pops
    @(negedge clk); cpuRxPop = 1; errOnEmptyEn = 0; #1;
    chk(!cpuBusErr, "R8 no bus error when option off", cpuBusErr, 0);
    tick();
    @(negedge clk); cpuRxPop = 1; errOnEmptyEn = 1; #1;
    chk(cpuBusErr, "R8 bus error on empty read", cpuBusErr, 1);
    chk(cpuRxData == 10'h0, "R7 empty pop returns zero", cpuRxData, 0);
    tick();
    chk(idxRdata[12:8] == 5'd0, "R7 count unchanged", idxRdata[12:8], 0);
    rxIn(8'h21, 1'b0, 1'b0);
    @(negedge clk); cpuRxPop = 1; #1;
    chk(!cpuBusErr, "R8 no bus error when not empty", cpuBusErr, 0);
    tick();
    errOnEmptyEn = 0;

    // R9: almost-empty level on transmit
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); cpuTxPush = 1; cpuTxData = 8'(i); tick();
      chk(txAlmostEmpty == (i + 1 <= 4), "R9 almost empty level", txAlmostEmpty, (i + 1 <= 4));
    end
    chk(!txEmpty, "R9 tx not empty", txEmpty, 0);

    // R5: transmit flush, push during flush edge dropped
    ctl(4'b1001);
    chk(ctlRdata[3] && idxRdata[4:0] == 5'd5, "R5 tx flush pending", ctlRdata, 4'b1001);
    @(negedge clk); cpuTxPush = 1; cpuTxData = 8'h99; tick();
    chk(!ctlRdata[3] && idxRdata[4:0] == 5'd0, "R5 tx flushed and cleared", idxRdata, 0);

    // R5: receive flush
    rxIn(8'h01, 1'b0, 1'b0);
    rxIn(8'h02, 1'b0, 1'b0);
    ctl(4'b0101);
    chk(ctlRdata[2] && idxRdata[12:8] == 5'd2, "R5 rx flush pending", ctlRdata, 4'b0101);
    @(negedge clk); tick();
    chk(!ctlRdata[2] && idxRdata[12:8] == 5'd0, "R5 rx flushed and cleared", idxRdata, 0);
    chk(ctlRdata == 4'b0001, "R4 enable kept after flush", ctlRdata, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule